// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block sits in the execute stage of a five-stage in-order RISC pipeline and chooses, separately for each of the two ALU operands, where the operand value comes from. There are three candidate sources. The first is the register-file value captured when the instruction left decode. The second is the result of the instruction one step ahead, now in the memory stage. The third is the result of the instruction two steps ahead, now in write-back. Operand A is chosen by the first source-register field of the executing instruction, and operand B by the second.

The choice is made by comparing register numbers. Each of the two older stages reports a destination register number and a register-write enable. A stage that writes register zero is never used as a source. When both older stages write the register that an operand needs, the younger memory-stage result is taken, because it is the more recent value of that register. The block drives the 2-bit select codes and also the selected operand values, which go to the ALU. The whole block is combinational.

Top module: `fwd_operand_unit`

## Requirements
- R1: When neither older stage qualifies for an operand, that operand's select is 00 and the operand equals its register-file value.
- R2: When the memory stage has its write enable set, a non-zero destination, and that destination equals the operand's source register, the select is 10 and the operand equals the memory-stage result.
- R3: When only the write-back stage qualifies under the same three conditions (write enable set, non-zero destination, destination equal to the source register), the select is 01 and the operand equals the write-back result.
- R4: When both stages qualify for the same operand, the memory-stage result wins: the select is 10.
- R5: A destination of register 0 never causes bypassing from either stage, even with the write enable set. This holds also when the source register is 0.
- R6: A stage whose write enable is low is never bypassed, even if its destination matches. A matching write-back stage that has its enable set then wins.
- R7: Operand A is compared only against the first source field and operand B only against the second. In the same cycle the two operands may take different sources.
- R8: The select code 11 is never driven. If the operand mux is given 11, it passes the register-file value, as for 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_a_reg | input | REG_AW | First source register number of the executing instruction |
| src_b_reg | input | REG_AW | Second source register number of the executing instruction |
| mem_wr_en | input | 1 | Memory-stage instruction writes a register |
| mem_dst_reg | input | REG_AW | Memory-stage destination register number |
| mem_result | input | DATA_W | Memory-stage ALU result |
| wb_wr_en | input | 1 | Write-back-stage instruction writes a register |
| wb_dst_reg | input | REG_AW | Write-back-stage destination register number |
| wb_result | input | DATA_W | Write-back-stage value |
| rf_val_a | input | DATA_W | Register-file value latched for operand A |
| rf_val_b | input | DATA_W | Register-file value latched for operand B |
| sel_a | output | 2 | Source select for operand A (00 register file, 01 write-back, 10 memory stage) |
| sel_b | output | 2 | Source select for operand B, same encoding |
| opnd_a | output | DATA_W | Selected operand A |
| opnd_b | output | DATA_W | Selected operand B |

## Verification
The two functions that fall in the same cycle are the memory-stage bypass and the write-back bypass. They collide when two consecutive older instructions both write the register that one operand reads. The bench provokes this with vectors in which both stages carry the same destination and have their enables set. It also runs a sweep of every register number with both stages writing it. It judges the outcome by requiring select 10 and the memory-stage data on the operand, except for register 0, where the register-file value must come through. Separate vectors place the two bypass kinds on different operands in the same cycle, so that each operand is checked to resolve independently.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    FWD_RF = 2'b00,
    FWD_WB = 2'b01,
    FWD_EX = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/fwd_match.sv
module fwd_match
  import fwd_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] src_reg,
  input  logic              mem_wr_en,
  input  logic [REG_AW-1:0] mem_dst_reg,
  input  logic              wb_wr_en,
  input  logic [REG_AW-1:0] wb_dst_reg,
  output fwd_sel_e          sel
);
  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  logic mem_hit;
  logic wb_hit;

  // Each stage qualifies on its own. The younger stage is checked first.
  assign mem_hit = mem_wr_en && (mem_dst_reg != ZERO_REG) && (mem_dst_reg == src_reg);
  assign wb_hit  = wb_wr_en  && (wb_dst_reg  != ZERO_REG) && (wb_dst_reg  == src_reg);

  always_comb begin
    sel = FWD_RF;
    if (mem_hit) begin
      sel = FWD_EX;
    end else if (wb_hit) begin
      sel = FWD_WB;
    end
  end

  always_comb begin
    AST_SEL_LEGAL: assert (sel != 2'b11); // R8
    if (!mem_wr_en && !wb_wr_en) begin
      AST_IDLE_NO_FWD: assert (sel == FWD_RF); // R6
    end
    if (mem_dst_reg == ZERO_REG && wb_dst_reg == ZERO_REG) begin
      AST_ZERO_NO_FWD: assert (sel == FWD_RF); // R5
    end
  end
endmodule

// File: rtl/fwd_mux.sv
module fwd_mux
  import fwd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic [DATA_W-1:0] rf_val,
  input  logic [DATA_W-1:0] wb_val,
  input  logic [DATA_W-1:0] mem_val,
  output logic [DATA_W-1:0] opnd
);
  always_comb begin
    case (sel)
      FWD_EX:  opnd = mem_val;
      FWD_WB:  opnd = wb_val;
      default: opnd = rf_val;   // 00 and the unused 11
    endcase
  end
endmodule

// File: rtl/fwd_operand_unit.sv
module fwd_operand_unit
  import fwd_pkg::*;
#(
  parameter int REG_AW = 5,
  parameter int DATA_W = 32
) (
  input  logic [REG_AW-1:0] src_a_reg,
  input  logic [REG_AW-1:0] src_b_reg,
  input  logic              mem_wr_en,
  input  logic [REG_AW-1:0] mem_dst_reg,
  input  logic [DATA_W-1:0] mem_result,
  input  logic              wb_wr_en,
  input  logic [REG_AW-1:0] wb_dst_reg,
  input  logic [DATA_W-1:0] wb_result,
  input  logic [DATA_W-1:0] rf_val_a,
  input  logic [DATA_W-1:0] rf_val_b,
  output logic [1:0]        sel_a,
  output logic [1:0]        sel_b,
  output logic [DATA_W-1:0] opnd_a,
  output logic [DATA_W-1:0] opnd_b
);
  localparam int NUM_OPS = 2;

  logic [REG_AW-1:0] src_reg [NUM_OPS];
  logic [DATA_W-1:0] rf_val  [NUM_OPS];
  logic [DATA_W-1:0] opnd    [NUM_OPS];
  fwd_sel_e          sel     [NUM_OPS];

  assign src_reg[0] = src_a_reg;
  assign src_reg[1] = src_b_reg;
  assign rf_val[0]  = rf_val_a;
  assign rf_val[1]  = rf_val_b;

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_op
    fwd_match #(.REG_AW(REG_AW)) u_match (
      .src_reg     (src_reg[i]),
      .mem_wr_en   (mem_wr_en),
      .mem_dst_reg (mem_dst_reg),
      .wb_wr_en    (wb_wr_en),
      .wb_dst_reg  (wb_dst_reg),
      .sel         (sel[i])
    );

    fwd_mux #(.DATA_W(DATA_W)) u_mux (
      .sel     (sel[i]),
      .rf_val  (rf_val[i]),
      .wb_val  (wb_result),
      .mem_val (mem_result),
      .opnd    (opnd[i])
    );

    // The mux output must follow the selector decision.
    always_comb begin
      if (sel[i] == FWD_EX) begin
        AST_EX_DATA: assert (opnd[i] == mem_result); // R2
      end
      if (sel[i] == FWD_RF) begin
        AST_RF_DATA: assert (opnd[i] == rf_val[i]); // R1
      end
      if (mem_wr_en && wb_wr_en && mem_dst_reg == wb_dst_reg && mem_dst_reg == src_reg[i]
          && mem_dst_reg != '0) begin
        AST_YOUNGER_WINS: assert (sel[i] == FWD_EX); // R4
      end
    end
  end

  assign sel_a  = sel[0];
  assign sel_b  = sel[1];
  assign opnd_a = opnd[0];
  assign opnd_b = opnd[1];
endmodule

// File: tb/sim_fwd_operand_unit.sv
module sim_fwd_operand_unit;
  localparam int CLK_PERIOD = 10;
  localparam int REG_AW = 5;
  localparam int DATA_W = 32;
  localparam int WATCHDOG = 5000;

  localparam logic [DATA_W-1:0] MEM_V = 32'hE0E0_0001;
  localparam logic [DATA_W-1:0] WB_V  = 32'hB0B0_0002;
  localparam logic [DATA_W-1:0] RFA_V = 32'hAAAA_0003;
  localparam logic [DATA_W-1:0] RFB_V = 32'h5555_0004;

  typedef struct packed {
    logic [4:0] rs;
    logic [4:0] rt;
    logic       mwe;
    logic [4:0] mrd;
    logic       wwe;
    logic [4:0] wrd;
    logic [1:0] ea;
    logic [1:0] eb;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{5'd3,  5'd4,  1'b0, 5'd3,  1'b0, 5'd4,  2'b00, 2'b00, 4'd6}, // R6 enables low
    '{5'd3,  5'd4,  1'b1, 5'd3,  1'b0, 5'd0,  2'b10, 2'b00, 4'd2}, // R2
    '{5'd3,  5'd4,  1'b0, 5'd0,  1'b1, 5'd4,  2'b00, 2'b01, 4'd3}, // R3
    '{5'd7,  5'd7,  1'b1, 5'd7,  1'b1, 5'd7,  2'b10, 2'b10, 4'd4}, // R4 both stages write r7
    '{5'd5,  5'd6,  1'b1, 5'd6,  1'b1, 5'd5,  2'b01, 2'b10, 4'd7}, // R7 mixed sources
    '{5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 5'd0,  2'b00, 2'b00, 4'd5}, // R5 register zero
    '{5'd9,  5'd2,  1'b1, 5'd1,  1'b1, 5'd8,  2'b00, 2'b00, 4'd1}, // R1 no match
    '{5'd31, 5'd31, 1'b1, 5'd31, 1'b0, 5'd31, 2'b10, 2'b10, 4'd2}, // R2 top register
    '{5'd12, 5'd13, 1'b1, 5'd0,  1'b1, 5'd12, 2'b01, 2'b00, 4'd5}, // R5 mem rd zero
    '{5'd4,  5'd4,  1'b0, 5'd4,  1'b1, 5'd4,  2'b01, 2'b01, 4'd6}, // R6 mem disabled
    '{5'd8,  5'd9,  1'b1, 5'd9,  1'b1, 5'd8,  2'b01, 2'b10, 4'd7}  // R7 mirrored
  };

  logic clk = 1'b0;
  logic [REG_AW-1:0] src_a_reg = '0, src_b_reg = '0, mem_dst_reg = '0, wb_dst_reg = '0;
  logic mem_wr_en = 1'b0, wb_wr_en = 1'b0;
  logic [DATA_W-1:0] mem_result = MEM_V, wb_result = WB_V, rf_val_a = RFA_V, rf_val_b = RFB_V;
  logic [1:0] sel_a, sel_b;
  logic [DATA_W-1:0] opnd_a, opnd_b;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  fwd_operand_unit #(.REG_AW(REG_AW), .DATA_W(DATA_W)) u0 (
    .src_a_reg, .src_b_reg, .mem_wr_en, .mem_dst_reg, .mem_result,
    .wb_wr_en, .wb_dst_reg, .wb_result, .rf_val_a, .rf_val_b,
    .sel_a, .sel_b, .opnd_a, .opnd_b
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DATA_W-1:0] pick(input logic [1:0] s, input logic [DATA_W-1:0] rf);
    if (s == 2'b10) return MEM_V;
    if (s == 2'b01) return WB_V;
    return rf;
  endfunction

  task automatic chk(input string req, input string what, input logic [DATA_W-1:0] act,
                     input logic [DATA_W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(posedge clk);
    src_a_reg   = v.rs;
    src_b_reg   = v.rt;
    mem_wr_en   = v.mwe;
    mem_dst_reg = v.mrd;
    wb_wr_en    = v.wwe;
    wb_dst_reg  = v.wrd;
    @(negedge clk);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    // Idle inputs: no bypass (R1)
    chk("R1", "idle sel_a", {30'd0, sel_a}, 32'd0);
    chk("R1", "idle opnd_a", opnd_a, RFA_V);
    chk("R1", "idle opnd_b", opnd_b, RFB_V);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d/v%0d", VECS[i].req, i);
      apply(VECS[i]);
      chk(tag, "sel_a", {30'd0, sel_a}, {30'd0, VECS[i].ea});
      chk(tag, "sel_b", {30'd0, sel_b}, {30'd0, VECS[i].eb});
      chk(tag, "opnd_a", opnd_a, pick(VECS[i].ea, RFA_V));
      chk(tag, "opnd_b", opnd_b, pick(VECS[i].eb, RFB_V));
    end

    // Sweep: both stages write the same register the operands read (R4, R5, R8)
    for (int r = 0; r < 32; r++) begin
      vec_t v;
      logic [1:0] e;
      e = (r == 0) ? 2'b00 : 2'b10;
      v = '{5'(r), 5'(r), 1'b1, 5'(r), 1'b1, 5'(r), e, e, 4'd4};
      apply(v);
      chk("R4", $sformatf("sweep r%0d sel_a", r), {30'd0, sel_a}, {30'd0, e});
      chk("R4", $sformatf("sweep r%0d opnd_b", r), opnd_b, pick(e, RFB_V));
      chk("R8", $sformatf("sweep r%0d sel_b not 11", r), {31'd0, sel_b == 2'b11}, 32'd0);
    end

    // Data change with fixed routing: operand follows new write-back value (R3)
    apply('{5'd10, 5'd11, 1'b0, 5'd0, 1'b1, 5'd10, 2'b01, 2'b00, 4'd3});
    wb_result = 32'h1234_5678;
    #1;
    chk("R3", "wb data follows", opnd_a, 32'h1234_5678);
    chk("R3", "opnd_b untouched", opnd_b, RFB_V);
    wb_result = WB_V;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG && !done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule